// File: doc/BRIEF.md
# Quasi-Bidirectional I/O Port

This block is one general-purpose I/O port of a small controller, one latch bit and one modelled pin driver for each pin. On the CPU side the port has a latch write strobe and two read strobes. One read strobe returns the latch contents. The other returns the pin levels, after they pass through a two-stage synchronizer. On the pin side the port gives separate drive-low and drive-high enables, an internal pull-up enable and an output enable. The pad cell outside the block turns these into an electrical level, and the resulting level comes back on `pin_in`.

A pin takes one of three sources. In normal I/O mode, a latch bit of 0 pulls the pin low. A latch bit of 1 releases the pin, so an external source can set the level, and the quasi-bidirectional variant then turns on a weak pull-up. Each pin can instead be set to carry an alternate-function output, and this output only reaches the pin while the latch bit for that pin holds 1. When the port carries external address or data, the internal bus bit drives the pin both high and low. In that mode the latch is ignored for driving and is protected from writes. The parameter `QUASI` picks the variant: 1 gives the pull-up, and 0 gives a true-bidirectional pin that floats.

Top module: `qb_port`

## Requirements
- R1: After reset the latch holds all ones, no pin is driven low or high, and the synchronizer holds all ones, so every pin starts as an input.
- R2: In normal mode, a pin whose latch bit is 0 has `drv_low`=1 and `drv_high`=0, whatever its alternate-function settings are.
- R3: In normal mode, a pin whose effective output is 1 has both driver enables at 0. `pull_en` is then 1 when `QUASI`=1 and 0 when `QUASI`=0. A pin that drives low has `pull_en`=0.
- R4: While `bus_mode`=1, each pin is driven from `bus_data`: bit 1 gives `drv_high`=1 and `drv_low`=0, bit 0 gives the reverse, and `pull_en` is 0.
- R5: A pin with `alt_sel` bit 1 has an effective output equal to its latch bit AND its `alt_out` bit. A pin with `alt_sel` bit 0 uses its latch bit alone.
- R6: With `rd_latch_en`=1, `rd_data` returns the latch contents, even when the pin level differs from them.
- R7: With only `rd_pin_en`=1, `rd_data` returns the `pin_in` value that was sampled two rising edges earlier.
- R8: A latch write (`wr_en`=1) takes effect at the next rising edge. While `bus_mode`=1 the write is ignored and the latch keeps its value.
- R9: If both read strobes are 1, the latch read wins. If neither strobe is 1, `rd_data` is all zeros.
- R10: `drv_low` and `drv_high` are never both 1 on the same pin. `out_en` is 1 exactly where one of the two is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | WIDTH | Value written to the latch |
| rd_pin_en | input | 1 | Strobe to read the synchronized pin levels |
| rd_latch_en | input | 1 | Strobe to read the latch contents |
| rd_data | output | WIDTH | Read result |
| bus_mode | input | 1 | 1: pins carry external bus bits |
| bus_data | input | WIDTH | Internal address/data bits used in bus mode |
| alt_sel | input | WIDTH | Per-pin alternate-function select |
| alt_out | input | WIDTH | Per-pin alternate-function output value |
| pin_in | input | WIDTH | Level seen at each pin |
| drv_low | output | WIDTH | Pull-down driver enable |
| drv_high | output | WIDTH | Strong pull-up driver enable |
| pull_en | output | WIDTH | Weak internal pull-up enable |
| out_en | output | WIDTH | Pin actively driven |

## Verification
The assertions run on every cycle and cover the following behaviours:
- the drivers never contend, and `out_en` matches the driver enables;
- in bus mode the drivers follow `bus_data`;
- in normal mode every pin with a zero latch bit drives low;
- a latch read returns the latch;
- the latch does not change during bus mode;
- the latch comes out of reset as all ones.

Only the bench scenarios can show two behaviours. One is the two-edge latency of pin reads, checked against a pin level that differs from the latch under load. The other is the gating of alternate-function outputs by the latch bit. A reference model in the bench compares all outputs on every cycle.

// File: rtl/qb_port.sv
module qb_port #(
  parameter int WIDTH = 8,
  parameter bit QUASI = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_pin_en,
  input  logic             rd_latch_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic             bus_mode,
  input  logic [WIDTH-1:0] bus_data,
  input  logic [WIDTH-1:0] alt_sel,
  input  logic [WIDTH-1:0] alt_out,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] drv_low,
  output logic [WIDTH-1:0] drv_high,
  output logic [WIDTH-1:0] pull_en,
  output logic [WIDTH-1:0] out_en
);
  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] sync1_q, sync2_q;
  logic [WIDTH-1:0] eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  latch_q <= ONES;
    else if (wr_en && !bus_mode) latch_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= ONES;
      sync2_q <= ONES;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign eff[i]      = latch_q[i] & (alt_sel[i] ? alt_out[i] : 1'b1);
    assign drv_low[i]  = bus_mode ? ~bus_data[i] : ~eff[i];
    assign drv_high[i] = bus_mode ?  bus_data[i] : 1'b0;
    assign pull_en[i]  = bus_mode ? 1'b0 : (QUASI & eff[i]);
  end

  assign out_en  = drv_low | drv_high;
  assign rd_data = rd_latch_en ? latch_q : (rd_pin_en ? sync2_q : '0);
endmodule

// File: rtl/qb_port_chk.sv
module qb_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_latch_en,
  input logic [WIDTH-1:0] rd_data,
  input logic             bus_mode,
  input logic [WIDTH-1:0] bus_data,
  input logic [WIDTH-1:0] drv_low,
  input logic [WIDTH-1:0] drv_high,
  input logic [WIDTH-1:0] out_en,
  input logic [WIDTH-1:0] latch_q
);
  a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_low & drv_high) == '0);

  a_r10_oe_matches: assert property (@(posedge clk) disable iff (!rst_n)
    out_en == (drv_low | drv_high));

  a_r4_bus_drives: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mode |-> (drv_high == bus_data && drv_low == ~bus_data));

  a_r2_zero_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_mode |-> ((~latch_q & ~drv_low) == '0));

  a_r6_latch_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_latch_en |-> rd_data == latch_q);

  a_r8_bus_holds_latch: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mode |=> $stable(latch_q));

  a_r1_reset_ones: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> latch_q == {WIDTH{1'b1}});
endmodule

bind qb_port qb_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_latch_en(rd_latch_en), .rd_data(rd_data),
  .bus_mode(bus_mode), .bus_data(bus_data), .drv_low(drv_low),
  .drv_high(drv_high), .out_en(out_en), .latch_q(latch_q)
);

// File: tb/qb_port_test.sv
`timescale 1ns/1ps
module qb_port_test;
  localparam int W = 8;
  localparam bit Q = 1'b1;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_pin_en = 0, rd_latch_en = 0, bus_mode = 0;
  logic [W-1:0] wr_data = '0, bus_data = '0, alt_sel = '0, alt_out = '0, pin_in = '1;
  logic [W-1:0] rd_data, drv_low, drv_high, pull_en, out_en;

  int errors = 0, checks = 0;
  logic [W-1:0] m_latch;
  logic [W-1:0] m_hist[$];

  always #10 clk = ~clk;

  qb_port #(.WIDTH(W), .QUASI(Q)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_pin_en(rd_pin_en), .rd_latch_en(rd_latch_en), .rd_data(rd_data),
    .bus_mode(bus_mode), .bus_data(bus_data), .alt_sel(alt_sel),
    .alt_out(alt_out), .pin_in(pin_in), .drv_low(drv_low),
    .drv_high(drv_high), .pull_en(pull_en), .out_en(out_en)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_latch = '1;
      m_hist = {};
      m_hist.push_back('1);
      m_hist.push_back('1);
    end else begin
      if (wr_en && !bus_mode) m_latch = wr_data;
      m_hist.push_back(pin_in);
      void'(m_hist.pop_front());
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [W-1:0] e_low, e_high, e_pull, e_rd;
      for (int i = 0; i < W; i++) begin
        logic e;
        e = m_latch[i] && (!alt_sel[i] || alt_out[i]);
        if (bus_mode) begin
          e_low[i] = !bus_data[i]; e_high[i] = bus_data[i]; e_pull[i] = 1'b0;
        end else begin
          e_low[i] = !e; e_high[i] = 1'b0; e_pull[i] = Q && e;
        end
      end
      if (rd_latch_en)    e_rd = m_latch;
      else if (rd_pin_en) e_rd = m_hist[0];
      else                e_rd = '0;
      check("R2/R4/R5 cycle drv_low", drv_low, e_low);
      check("R4 cycle drv_high", drv_high, e_high);
      check("R3 cycle pull_en", pull_en, e_pull);
      check("R10 cycle out_en", out_en, e_low | e_high);
      check("R6/R7/R9 cycle rd_data", rd_data, e_rd);
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_latch(input logic [W-1:0] v);
    wr_en = 1; wr_data = v;
    cyc();
    wr_en = 0;
    #5;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    #5;
    // R1 reset state
    rd_latch_en = 1; #1; check("R1 latch after reset", rd_data, 8'hFF);
    rd_latch_en = 0; rd_pin_en = 1; #1; check("R1 sync after reset", rd_data, 8'hFF);
    rd_pin_en = 0;
    check("R1 no drive low", drv_low, 8'h00);
    check("R1 no drive high", drv_high, 8'h00);

    // R2 / R3
    cyc();
    write_latch(8'h5A);
    check("R2 zero bits drive low", drv_low, 8'hA5);
    check("R3 no high drive", drv_high, 8'h00);
    check("R3 pull-up on ones", pull_en, 8'h5A);
    check("R10 out_en", out_en, 8'hA5);

    // R6 / R7 pin differs from latch under load
    pin_in = 8'h10;
    cyc(3); #4;
    rd_latch_en = 1; #1; check("R6 latch read under load", rd_data, 8'h5A);
    rd_latch_en = 0; rd_pin_en = 1; #1; check("R7 pin read under load", rd_data, 8'h10);
    rd_latch_en = 1; #1; check("R9 latch read priority", rd_data, 8'h5A);
    rd_latch_en = 0; rd_pin_en = 0; #1; check("R9 idle read zero", rd_data, 8'h00);

    // R7 latency
    rd_pin_en = 1;
    cyc(); pin_in = 8'hC3;
    cyc(); #4; check("R7 one edge later old value", rd_data, 8'h10);
    cyc(); #4; check("R7 two edges later new value", rd_data, 8'hC3);
    rd_pin_en = 0;

    // R5 alternate function
    write_latch(8'hFF);
    alt_sel = 8'h0F; alt_out = 8'h05; #2;
    check("R5 alt follows when latch is one", drv_low, 8'h0A);
    check("R5 alt pull", pull_en, 8'hF5);
    write_latch(8'h00);
    check("R5 latch zero blocks alt", drv_low, 8'hFF);
    alt_out = 8'hFF; #2;
    check("R5 latch zero blocks alt high", drv_low, 8'hFF);
    alt_sel = 8'h00; alt_out = 8'h00;

    // R4 / R8 bus mode
    bus_mode = 1; bus_data = 8'h3C; #2;
    check("R4 bus high", drv_high, 8'h3C);
    check("R4 bus low", drv_low, 8'hC3);
    check("R4 no pull", pull_en, 8'h00);
    check("R10 bus out_en", out_en, 8'hFF);
    write_latch(8'h11);
    bus_data = 8'hA0; #2;
    check("R4 bus follows data", drv_high, 8'hA0);
    bus_mode = 0; #2;
    rd_latch_en = 1; #1; check("R8 write ignored in bus mode", rd_data, 8'h00);
    rd_latch_en = 0;
    write_latch(8'h77);
    rd_latch_en = 1; #1; check("R8 write after bus mode", rd_data, 8'h77);
    rd_latch_en = 0;

    // random traffic compared each cycle by the model
    for (int k = 0; k < 400; k++) begin
      @(posedge clk); #1;
      wr_en = ($urandom % 4) == 0; wr_data = W'($urandom);
      rd_pin_en = $urandom % 2; rd_latch_en = ($urandom % 3) == 0;
      bus_mode = ($urandom % 5) == 0; bus_data = W'($urandom);
      alt_sel = W'($urandom); alt_out = W'($urandom); pin_in = W'($urandom);
    end
    cyc(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule